// File: doc/BRIEF.md
# Memory Precharge Interval Enforcer

This block holds the 16-bit configuration word of an external memory controller and enforces the minimum idle gap that must pass between the end of one memory access and the start of the next. The gap has the same meaning on every supported interface. For DRAM it is the time from row strobe going inactive to row strobe going active again. For synchronous DRAM it is the time from the precharge command to the next bank-activate command. For pseudo-SRAM it is the time from chip enable going inactive to chip enable going active again. The controller pulses `pre_start` when the closing edge of an access occurs. It may begin the next access only while `act_ok` is high.

The gap length comes from the two-bit precharge code in bits 15:14 of the configuration word. The code is read through one of two tables. The normal table gives short gaps. A stretched table gives longer gaps and applies to the first activation after the memory leaves self-refresh. A pulse on `sr_exit` arms the stretched table for one gap. The other fields of the word (RAS-to-CAS delay, write latency, RAS active time, burst enable, size, address multiplex select, refresh enable, refresh mode, EDO mode) are only stored and read back.

The word is cleared only by the power-on reset. The manual reset clears the timer, but the word keeps its contents.

Top module: `precharge_gap_ctrl`

## Requirements
- R1: A cycle with `bus_we` high stores `bus_wdata` into the word, with bit 7 forced to 0. From the next cycle `bus_rdata` shows the stored word. Fields: 15:14 precharge code, 13:12 RAS-to-CAS, 11:10 write latency, 9:8 RAS active, 6 burst, 5 size, 4:3 address multiplex, 2 refresh enable, 1 refresh mode, 0 EDO.
- R2: Bit 7 of `bus_rdata` always reads 0. Writing a 1 to bit 7 has no effect.
- R3: While `por_n` is low, the word reads 0x0000 and `act_ok` is high.
- R4: While `mrst_n` is low, `act_ok` is high and the self-refresh flag is cleared. The stored word keeps its value through the manual reset and whenever `bus_we` is low.
- R5: `pre_start` is sampled at a clock edge. After that edge, `act_ok` stays low for exactly N cycles and is high again after the N-th following edge. With the self-refresh flag clear, precharge codes 0, 1, 2 and 3 give N = 1, 2, 3 and 4.
- R6: When the self-refresh flag is set, or `sr_exit` is high in the same cycle as `pre_start`, codes 0, 1, 2 and 3 give N = 2, 5, 8 and 11.
- R7: A pulse on `sr_exit` sets a sticky flag. The flag stretches only the next gap and clears when that gap completes. A pulse during a normal gap does not lengthen that gap; it stretches the one after it.
- R8: A `pre_start` pulse while a gap is being counted reloads the full count from that edge.
- R9: The precharge code is taken at the `pre_start` edge. A write during a count does not change the gap in progress; it applies to the next gap.
- R10: While `act_ok` is high and `pre_start` is low, `act_ok` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| mrst_n | input | 1 | Manual reset, active low, asynchronous; clears the timer and flag only |
| bus_we | input | 1 | Write strobe for the configuration word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Current configuration word |
| pre_start | input | 1 | One-cycle pulse marking the start of a precharge gap |
| sr_exit | input | 1 | One-cycle pulse signalling exit from self-refresh |
| act_ok | output | 1 | High when a new activation is allowed |

## Verification
The bench measures how many cycles `act_ok` stays low for every code in both tables. An off-by-one counter would miss by one cycle, and a wrong table would give the wrong length. Several cases check how long the self-refresh flag stays armed:
- A flag that never clears would stretch the gap after the stretched one.
- A flag consumed at the start edge instead of on completion would break a restart inside a stretched gap.
- A flag consumed by a normal gap would never stretch the gap that follows it.

Other cases check timing details:
- A restart in the middle of a count must reload the full count. A design that ignores the restart would release the memory too early.
- A write in the middle of a count must not change that gap. A design that reads the code live would shorten the gap in progress.

The manual reset must keep the word intact, and bit 7 must stay 0 even when written with a 1.

// File: rtl/pgap_pkg.sv
package pgap_pkg;

  localparam int unsigned WORD_W   = 16;
  localparam int unsigned CODE_W   = 2;
  localparam int unsigned RSVD_BIT = 7;

  // Every writable bit is set; the read-only bit is cleared.
  localparam logic [WORD_W-1:0] WR_MASK = ~(WORD_W'(1) << RSVD_BIT);

  // Longest gap comes from the stretched table at the top code.
  localparam int unsigned MAX_CODE = (1 << CODE_W) - 1;
  localparam int unsigned MAX_GAP  = 3 * MAX_CODE + 2;
  localparam int unsigned GAP_W    = $clog2(MAX_GAP + 1);

  typedef logic [GAP_W-1:0] gap_t;

  typedef struct packed {
    logic [1:0] pchg;      // 15:14 gap code, the only field with timing
    logic [1:0] rcd;       // 13:12
    logic [1:0] wr_lat;    // 11:10
    logic [1:0] ras_act;   // 9:8
    logic       rsvd;      // 7, always 0
    logic       burst;     // 6
    logic       size;      // 5
    logic [1:0] amux;      // 4:3
    logic       rf_en;     // 2
    logic       rf_mode;   // 1
    logic       edo;       // 0
  } ctl_word_t;

  // Normal table: code + 1; stretched table: 3*code + 2.
  function automatic gap_t gap_len(input logic [CODE_W-1:0] code,
                                   input logic stretched);
    int unsigned c;
    c = int'(code);
    if (stretched) gap_len = GAP_W'(3 * c + 2);
    else           gap_len = GAP_W'(c + 1);
  endfunction

endpackage

// File: rtl/pgap_regfile.sv
module pgap_regfile
  import pgap_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              we,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  output logic [CODE_W-1:0] pchg_code
);

  ctl_word_t word_q;

  // Only the power-on reset reaches this register.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)  word_q <= '0;
    else if (we) word_q <= ctl_word_t'(wdata & WR_MASK);
  end

  assign rdata     = W'(word_q);
  assign pchg_code = word_q.pchg;

endmodule

// File: rtl/pgap_srflag.sv
module pgap_srflag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic consume_i,
  output logic flag_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag_o <= 1'b0;
    else if (set_i)     flag_o <= 1'b1;
    else if (consume_i) flag_o <= 1'b0;
  end

endmodule

// File: rtl/pgap_timer.sv
module pgap_timer
  import pgap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              stretch_i,
  output logic              ready_o,
  output logic              done_str_o
);

  gap_t cnt_q;
  logic str_q;

  // The code and the table choice are captured at the start edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      str_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= gap_len(code_i, stretch_i);
      str_q <= stretch_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - gap_t'(1);
    end
  end

  assign ready_o    = (cnt_q == '0);
  // Fires in the last cycle of a stretched gap that is not being restarted.
  assign done_str_o = (cnt_q == gap_t'(1)) && str_q && !start_i;

endmodule

// File: rtl/precharge_gap_ctrl.sv
module precharge_gap_ctrl
  import pgap_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              mrst_n,
  input  logic              bus_we,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              pre_start,
  input  logic              sr_exit,
  output logic              act_ok
);

  logic              tmr_rst_n;
  logic [CODE_W-1:0] code;
  logic              sr_flag;
  logic              done_str;

  assign tmr_rst_n = por_n & mrst_n;

  pgap_regfile #(.W(WORD_W)) u_reg (
    .clk       (clk),
    .por_n     (por_n),
    .we        (bus_we),
    .wdata     (bus_wdata),
    .rdata     (bus_rdata),
    .pchg_code (code)
  );

  pgap_srflag u_flag (
    .clk       (clk),
    .rst_n     (tmr_rst_n),
    .set_i     (sr_exit),
    .consume_i (done_str),
    .flag_o    (sr_flag)
  );

  pgap_timer u_tmr (
    .clk        (clk),
    .rst_n      (tmr_rst_n),
    .start_i    (pre_start),
    .code_i     (code),
    .stretch_i  (sr_flag | sr_exit),
    .ready_o    (act_ok),
    .done_str_o (done_str)
  );

endmodule

// File: rtl/pgap_chk.sv
module pgap_chk
  import pgap_pkg::*;
(
  input logic              clk,
  input logic              por_n,
  input logic              mrst_n,
  input logic              bus_we,
  input logic [WORD_W-1:0] bus_wdata,
  input logic [WORD_W-1:0] bus_rdata,
  input logic              pre_start,
  input logic              act_ok
);

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
    bus_rdata[RSVD_BIT] == 1'b0);

  // R1
  write_lands_chk: assert property (@(posedge clk) disable iff (!por_n)
    bus_we |=> bus_rdata == ($past(bus_wdata) & WR_MASK));

  // R4
  word_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    !bus_we |=> $stable(bus_rdata));

  // R4
  mrst_ready_chk: assert property (@(posedge clk) disable iff (!por_n)
    !mrst_n |-> act_ok);

  // R5
  start_blocks_chk: assert property (@(posedge clk) disable iff (!por_n || !mrst_n)
    pre_start |=> !act_ok);

  // R10
  idle_stays_chk: assert property (@(posedge clk) disable iff (!por_n || !mrst_n)
    act_ok && !pre_start |=> act_ok);

endmodule

bind precharge_gap_ctrl pgap_chk u_pgap_chk (
  .clk       (clk),
  .por_n     (por_n),
  .mrst_n    (mrst_n),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pre_start (pre_start),
  .act_ok    (act_ok)
);

// File: tb/test_precharge_gap_ctrl.sv
`timescale 1ns/1ps
module test_precharge_gap_ctrl;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        mrst_n = 1'b1;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        pre_start = 1'b0;
  logic        sr_exit = 1'b0;
  logic        act_ok;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  precharge_gap_ctrl i_precharge_gap_ctrl (
    .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pre_start(pre_start),
    .sr_exit(sr_exit), .act_ok(act_ok)
  );

  // {stretched, code, expected low cycles}
  localparam logic [8:0] VEC [0:9] = '{
    {1'b0, 2'd0, 6'd1},  {1'b0, 2'd1, 6'd2},
    {1'b1, 2'd0, 6'd2},  {1'b0, 2'd2, 6'd3},
    {1'b1, 2'd1, 6'd5},  {1'b0, 2'd3, 6'd4},
    {1'b1, 2'd2, 6'd8},  {1'b0, 2'd1, 6'd2},
    {1'b1, 2'd3, 6'd11}, {1'b0, 2'd3, 6'd4}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] v);
    @(negedge clk); bus_we = 1'b1; bus_wdata = v;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic pulse_sr();
    @(negedge clk); sr_exit = 1'b1;
    @(negedge clk); sr_exit = 1'b0;
  endtask

  // Start a gap and count the sampled cycles with act_ok low.
  task automatic run_gap(input logic sr_mid, input logic wr_mid,
                         input logic [15:0] wval, input int restart_at,
                         output int len);
    @(negedge clk); pre_start = 1'b1;
    @(negedge clk); pre_start = 1'b0;
    sr_exit = sr_mid; bus_we = wr_mid; bus_wdata = wval;
    len = 0;
    while (!act_ok && len < 40) begin
      len++;
      pre_start = (len == restart_at);
      @(negedge clk);
      sr_exit = 1'b0; bus_we = 1'b0; pre_start = 1'b0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int len;
    repeat (3) @(negedge clk);
    check("R3 word", bus_rdata, 16'h0000);
    check("R3 ready", act_ok, 1);
    por_n = 1'b1;
    @(negedge clk);

    // Table walk
    for (int i = 0; i < 10; i++) begin
      wr({VEC[i][7:6], 14'h1235});
      if (VEC[i][8]) pulse_sr();
      run_gap(1'b0, 1'b0, 16'h0, 0, len);
      check(VEC[i][8] ? "R6 stretched gap" : "R5 normal gap", len, int'(VEC[i][5:0]));
    end

    // R1 / R2: read-back and the read-only bit
    wr(16'hFFFF);
    check("R2 bit7 masked", bus_rdata, 16'hFF7F);
    wr(16'hA5A5);
    check("R1 readback", bus_rdata, 16'hA525);

    // R7: the flag covers only the next gap
    wr(16'hC000);
    pulse_sr();
    run_gap(1'b0, 1'b0, 16'h0, 0, len);
    check("R7 armed gap", len, 11);
    run_gap(1'b0, 1'b0, 16'h0, 0, len);
    check("R7 flag cleared", len, 4);

    // R7: a pulse during a normal gap is deferred to the next gap
    wr(16'h4000);
    run_gap(1'b1, 1'b0, 16'h0, 0, len);
    check("R7 current gap unchanged", len, 2);
    run_gap(1'b0, 1'b0, 16'h0, 0, len);
    check("R7 deferred stretch", len, 5);

    // R6: sr_exit in the same cycle as the start
    wr(16'h0000);
    @(negedge clk); pre_start = 1'b1; sr_exit = 1'b1;
    @(negedge clk); pre_start = 1'b0; sr_exit = 1'b0;
    len = 0;
    while (!act_ok && len < 40) begin len++; @(negedge clk); end
    check("R6 same-cycle exit", len, 2);

    // R8: restart reloads the count
    wr(16'hC000);
    run_gap(1'b0, 1'b0, 16'h0, 2, len);
    check("R8 restart", len, 6);

    // R8: restart inside a stretched gap keeps the stretch
    pulse_sr();
    run_gap(1'b0, 1'b0, 16'h0, 3, len);
    check("R8 restart stretched", len, 14);
    run_gap(1'b0, 1'b0, 16'h0, 0, len);
    check("R7 cleared after restart", len, 4);

    // R9: a write during the count only affects the next gap
    run_gap(1'b0, 1'b1, 16'h0000, 0, len);
    check("R9 gap in progress", len, 4);
    check("R9 new word", bus_rdata, 16'h0000);
    run_gap(1'b0, 1'b0, 16'h0, 0, len);
    check("R9 next gap", len, 1);

    // R4: the manual reset keeps the word, frees the timer and drops the flag
    wr(16'hC0A6);
    pulse_sr();
    @(negedge clk); pre_start = 1'b1;
    @(negedge clk); pre_start = 1'b0;
    check("R5 low after start", act_ok, 0);
    mrst_n = 1'b0;
    @(negedge clk);
    check("R4 ready in mrst", act_ok, 1);
    check("R4 word kept", bus_rdata, 16'hC026);
    mrst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 idle stays ready", act_ok, 1);
    run_gap(1'b0, 1'b0, 16'h0, 0, len);
    check("R4 flag dropped", len, 4);

    // R3: a power-on reset clears the word
    @(negedge clk); por_n = 1'b0;
    @(negedge clk);
    check("R3 por clears", bus_rdata, 16'h0000);
    por_n = 1'b1;
    @(negedge clk);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule